// File: doc/BRIEF.md
# Serial Word Transmit Shifter

This block turns a stream of parallel words into a single-bit serial stream running at the bit clock. Once in every word period it asks the word source (the read side of a word FIFO) for the next word, captures it and shifts it out one bit per clock cycle, with no idle gap between words. From the same bit counter it also produces a word-rate clock, the bit clock divided by the word width, for the upstream logic that fills the FIFO.

A static order input picks whether the word's lowest or highest bit goes out first. An active-low squelch input forces the serial line to zero at the output stage without disturbing the word boundaries. A disable input turns off a registered enable meant to gate a forwarded copy of the bit clock. The bit clock is an ordinary synthesizable clock here. The clock source, the line drivers and the electrical levels are outside this block.

Top module: `txser_shifter`

## Requirements
- R1: While `rstN` is low, `serialOut`, `wordClk` and `bitClkEn` are 0 and `wordLoad` is 1. The bit counter sits at zero, so the first rising edge after reset captures a word.
- R2: `wordLoad` is high for exactly one cycle in every 16 bit-clock cycles. A 16-bit word is therefore sent as 16 consecutive serial bits, with the next word loaded on the cycle after the last bit.
- R3: With `msbFirst` = 0 at the load edge, `serialOut` shows `wordIn[0]` after that edge, then bits 1 through 15 on the following 15 edges.
- R4: With `msbFirst` = 1 at the load edge, `serialOut` shows `wordIn[15]` after that edge, then bits 14 down to 0.
- R5: `serialOut` is a register that changes only on the rising bit-clock edge. The bit shown after the k-th edge following the load edge (k = 0..15) is the k-th bit of the word in transmit order.
- R6: `wordClk` has a period of 16 bit-clock cycles. It is low while the bit counter is 0..7 and high while it is 8..15, so it is low in the cycle in which `wordLoad` is high.
- R7: When `squelchN` is 0 at a rising edge, the bit produced at that edge is 0. Bit positions keep advancing while squelched, so the bits after squelch is released belong to their normal positions.
- R8: `bitClkEn` equals the inverse of `clkDisable` sampled at the previous rising edge.
- R9: `msbFirst` is sampled only at the load edge. Changing it in the middle of a word has no effect on the order of that word's remaining bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wordIn | input | 16 | Word from the FIFO read side, captured when `wordLoad` is high |
| msbFirst | input | 1 | 1: bit 15 first; 0: bit 0 first |
| squelchN | input | 1 | Active-low squelch; 0 forces the serial output to zero |
| clkDisable | input | 1 | 1 turns off the forwarded bit-clock enable |
| wordLoad | output | 1 | Read strobe to the FIFO, one cycle in 16 |
| wordClk | output | 1 | Bit clock divided by 16 |
| serialOut | output | 1 | Serial data |
| bitClkEn | output | 1 | Enable for the forwarded bit clock |

## Verification
The assertions assume that `wordIn` is valid at every edge where `wordLoad` is high. They also assume that `msbFirst` and `squelchN` are settled before the rising edge at which they are sampled. The bench meets these assumptions by changing every input only on the falling edge, right after it has sampled the outputs. It presents each new word in the half cycle in which it sees `wordLoad` high. Mid-word changes of squelch and order are made on falling edges, so each one is attributed to a known bit position.

// File: rtl/txser_pkg.sv
package txser_pkg;
  // Strobes from the sequencer to the shift datapath
  typedef struct packed {
    logic loadWord;   // capture a new word this cycle
    logic shiftBit;   // advance the shift register this cycle
  } serStrobe_t;
endpackage

// File: rtl/txser_ctrl.sv
module txser_ctrl
  import txser_pkg::*;
#(
  parameter int WORD_BITS = 16   // must be a power of two
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clkDisable,
  output serStrobe_t strobe,
  output logic       wordLoad,
  output logic       wordClk,
  output logic       bitClkEn
);
  localparam int CNT_W = $clog2(WORD_BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_BITS - 1);

  logic [CNT_W-1:0] bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bitCnt <= '0;
    else if (bitCnt == LAST) bitCnt <= '0;
    else bitCnt <= bitCnt + 1'b1;
  end

  // Top counter bit is a registered, glitch-free divide-by-WORD_BITS
  assign wordClk = bitCnt[CNT_W-1];

  always_comb begin
    strobe.loadWord = (bitCnt == '0);
    strobe.shiftBit = !strobe.loadWord;
  end
  assign wordLoad = strobe.loadWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bitClkEn <= 1'b0;
    else bitClkEn <= !clkDisable;
  end

  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (bitCnt == LAST) |=> (bitCnt == '0)); // R2
  AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    wordLoad |=> !wordLoad); // R2
  AST_CLK_GATE: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (bitClkEn == !$past(clkDisable))); // R8
endmodule

// File: rtl/txser_datapath.sv
module txser_datapath
  import txser_pkg::*;
#(
  parameter int WORD_BITS = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  serStrobe_t           strobe,
  input  logic [WORD_BITS-1:0] wordIn,
  input  logic                 msbFirst,
  input  logic                 squelchN,
  output logic                 serialOut
);
  logic [WORD_BITS-1:0] reversedWord;
  logic [WORD_BITS-1:0] orderedWord;
  logic [WORD_BITS-1:0] shReg;
  logic                 nextBit;

  for (genvar i = 0; i < WORD_BITS; i++) begin : g_rev
    assign reversedWord[i] = wordIn[WORD_BITS-1-i];
  end

  // Transmit order is fixed at load time; bit 0 of orderedWord goes first
  assign orderedWord = msbFirst ? reversedWord : wordIn;

  always_comb begin
    nextBit = strobe.loadWord ? orderedWord[0] : shReg[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg     <= '0;
      serialOut <= 1'b0;
    end else begin
      if (strobe.loadWord) shReg <= orderedWord >> 1;
      else if (strobe.shiftBit) shReg <= shReg >> 1;
      // Squelch at the output stage only, so alignment is kept
      serialOut <= nextBit & squelchN;
    end
  end

  AST_SQUELCH_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !squelchN |=> !serialOut); // R7
  AST_FIRST_LSB: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadWord && !msbFirst && squelchN) |=> (serialOut == $past(wordIn[0]))); // R3
  AST_FIRST_MSB: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadWord && msbFirst && squelchN) |=> (serialOut == $past(wordIn[WORD_BITS-1]))); // R4
endmodule

// File: rtl/txser_shifter.sv
module txser_shifter
  import txser_pkg::*;
#(
  parameter int WORD_BITS = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [WORD_BITS-1:0] wordIn,
  input  logic                 msbFirst,
  input  logic                 squelchN,
  input  logic                 clkDisable,
  output logic                 wordLoad,
  output logic                 wordClk,
  output logic                 serialOut,
  output logic                 bitClkEn
);
  serStrobe_t strobe;

  txser_ctrl #(.WORD_BITS(WORD_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .clkDisable(clkDisable),
    .strobe(strobe), .wordLoad(wordLoad), .wordClk(wordClk), .bitClkEn(bitClkEn)
  );

  txser_datapath #(.WORD_BITS(WORD_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wordIn(wordIn),
    .msbFirst(msbFirst), .squelchN(squelchN), .serialOut(serialOut)
  );

  AST_LOAD_WCLK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wordClk) |-> wordLoad); // R6
endmodule

// File: tb/txser_shifter_test.sv
module txser_shifter_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] wordIn = '0;
  logic msbFirst = 1'b0;
  logic squelchN = 1'b1;
  logic clkDisable = 1'b0;
  logic wordLoad, wordClk, serialOut, bitClkEn;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  txser_shifter uut (
    .clk(clk), .rstN(rstN), .wordIn(wordIn), .msbFirst(msbFirst),
    .squelchN(squelchN), .clkDisable(clkDisable), .wordLoad(wordLoad),
    .wordClk(wordClk), .serialOut(serialOut), .bitClkEn(bitClkEn)
  );

  // {msbFirst, squelchN, word}
  localparam logic [17:0] VEC [8] = '{
    {1'b0, 1'b1, 16'hA5C3}, {1'b1, 1'b1, 16'hA5C3},
    {1'b0, 1'b1, 16'h0001}, {1'b1, 1'b1, 16'h0001},
    {1'b0, 1'b1, 16'h8000}, {1'b1, 1'b1, 16'hFFFF},
    {1'b0, 1'b0, 16'hFFFF}, {1'b1, 1'b1, 16'h1234}
  };
  // wordClk after edges 1..16 of a word: high for counter 8..15
  localparam logic [15:0] WCLK_EXP = 16'h7F80;
  localparam logic [15:0] LOAD_EXP = 16'h8000;

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expBits(input logic [15:0] w, input logic msb, input logic sq);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = msb ? w[15-i] : w[i];
    return sq ? r : 16'h0000;
  endfunction

  // Entered at a falling edge where wordLoad is high
  task automatic runWord(input logic [15:0] w, input logic msb, input logic sq,
                         input int flipAt, input int sqLowAt, input int sqHighAt,
                         output logic [15:0] got, output logic [15:0] loads, output logic [15:0] wclk);
    wordIn = w; msbFirst = msb; squelchN = sq;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      got[k] = serialOut; loads[k] = wordLoad; wclk[k] = wordClk;
      if (k == flipAt) msbFirst = !msbFirst;
      if (k == sqLowAt) squelchN = 1'b0;
      if (k == sqHighAt) squelchN = 1'b1;
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [15:0] got, loads, wclk, exp;
    // R1 reset state
    repeat (3) @(negedge clk);
    check(serialOut == 0 && wordClk == 0 && bitClkEn == 0 && wordLoad == 1, "R1",
          {12'h0, serialOut, wordClk, bitClkEn, wordLoad}, 16'h0001);
    rstN = 1'b1;

    // Vector table: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < 8; v++) begin
      runWord(VEC[v][15:0], VEC[v][17], VEC[v][16], -1, -1, -1, got, loads, wclk);
      exp = expBits(VEC[v][15:0], VEC[v][17], VEC[v][16]);
      check(got == exp, VEC[v][16] ? (VEC[v][17] ? "R4/R5" : "R3/R5") : "R7", got, exp);
      check(loads == LOAD_EXP, "R2", loads, LOAD_EXP);
      check(wclk == WCLK_EXP, "R6", wclk, WCLK_EXP);
    end

    // R9: order flipped mid-word keeps the order captured at load
    runWord(16'h00FF, 1'b0, 1'b1, 3, -1, -1, got, loads, wclk);
    check(got == 16'h00FF, "R9", got, 16'h00FF);

    // R7: squelch over bits 4..7 keeps alignment of the rest
    runWord(16'hFFFF, 1'b0, 1'b1, -1, 3, 7, got, loads, wclk);
    check(got == 16'hFF0F, "R7", got, 16'hFF0F);

    // R2 continuity: back-to-back word after mid-word activity
    runWord(16'hC001, 1'b1, 1'b1, -1, -1, -1, got, loads, wclk);
    exp = expBits(16'hC001, 1'b1, 1'b1);
    check(got == exp, "R2", got, exp);

    // R8 forwarded clock enable
    check(bitClkEn == 1'b1, "R8", {15'h0, bitClkEn}, 16'h0001);
    clkDisable = 1'b1;
    @(negedge clk);
    check(bitClkEn == 1'b0, "R8", {15'h0, bitClkEn}, 16'h0000);
    clkDisable = 1'b0;
    @(negedge clk);
    check(bitClkEn == 1'b1, "R8", {15'h0, bitClkEn}, 16'h0001);

    // R1 reset again mid-word
    rstN = 1'b0;
    @(negedge clk);
    check(serialOut == 0 && wordClk == 0 && bitClkEn == 0 && wordLoad == 1, "R1",
          {12'h0, serialOut, wordClk, bitClkEn, wordLoad}, 16'h0001);
    finishRun();
  end
endmodule